// File: doc/BRIEF.md
# General-Purpose I/O Port

This block is a byte-wide bidirectional pin port that sits on a small peripheral register bus. Software chooses, per pin, whether the pin drives the pad or listens to it. One shared data bit per pin does double duty: on a driven pin it is the level put on the pad, and on a listening pin it switches on a weak pull-up. A chip-wide input can veto every pull-up at once.

Incoming pad levels pass through a multi-stage synchronizer before software can read them. A sleep input freezes that sampling so the readback value stays still. Every bus access acts on all pins of the port together. The pad is modelled as three separate signals: input level, output level and output enable, plus one pull-up enable per pin.

The bus has no handshake. A write lands on the next rising clock edge. Read data is a plain combinational function of the address while the read strobe is high, so there is no valid/ready pairing and no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: When reset is asserted (rst_n low), the direction and data registers clear at once, without waiting for a clock edge, so pad_oe, pad_out and pad_pu are all zero.
- R2: A write to address 0 loads the direction register on the next rising edge. A 1 bit makes that pin drive the pad (pad_oe high); a 0 bit makes it an input.
- R3: A write to address 1 loads the data register on the next rising edge. On each pin whose direction bit is 1, pad_out equals that pin's data bit.
- R4: On each pin whose direction bit is 0, pad_out and pad_oe are 0, and pad_pu equals that pin's data bit, as long as pud_all is low.
- R5: While pud_all is high, pad_pu is zero on every pin, whatever the register contents.
- R6: The pin readback at address 2 returns pad_in after two rising edges (SYNC_STAGES = 2), never the raw pad. After only one edge it still shows the old value.
- R7: While sleep is high, the pin readback holds its value even if pad_in changes. Sampling resumes once sleep returns low.
- R8: Writes to address 2 or address 3 change neither the direction register nor the data register.
- R9: With bus_rd high, address 0 returns the direction register, address 1 returns the data register and address 3 returns zero. With bus_rd low, bus_rdata is zero.
- R10: pad_out is never high on a pin whose pad_oe is low, so a pin's drive enable and driven level take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pud_all | input | 1 | Global pull-up disable |
| sleep | input | 1 | Freezes input sampling while high |
| bus_addr | input | 2 | Register select: 0 direction, 1 data, 2 pin readback |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output levels |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |

## Verification
The bench uses the default parameters, WIDTH = 8 and SYNC_STAGES = 2. The full byte lets mixed patterns put driven pins, pulled-up inputs and plain inputs side by side in a single word. With two stages, the one-edge and two-edge points of the readback delay can each be sampled at a negative edge. That includes the boundary where the readback is one edge short of the new value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } gp_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  gp_sel_e          sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q
);
  // Direction and data registers; asynchronous clear puts every pin into input mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr) begin
      if (sel == SEL_DIR)  dir_q  <= wdata;
      if (sel == SEL_DATA) data_q <= wdata;
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> dir_q == $past(wdata));

  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SEL_PIN || sel == SEL_NONE)) |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_q
);
  logic [WIDTH-1:0] stg [STAGES];

  // First stage samples the pad; the whole chain stands still while hold is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stg[0] <= '0;
    else if (!hold) stg[0] <= pad_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stg[s] <= '0;
      else if (!hold) stg[s] <= stg[s-1];
    end
  end

  assign pin_q = stg[STAGES-1];

  // R7
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(pin_q));

  // R6
  chain_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> pin_q == $past(stg[STAGES-2]));
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic             pud_all,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  // Per-pin pad control: the data bit is the driven level on outputs and the pull-up request on inputs
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    always_comb begin
      pad_oe[p]  = dir_q[p];
      pad_out[p] = dir_q[p] & data_q[p];
      pad_pu[p]  = ~dir_q[p] & data_q[p] & ~pud_all;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pud_all,
  input  logic             sleep,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  gp_sel_e          sel;
  logic [WIDTH-1:0] dir_q, data_q, pin_q;

  assign sel = gp_sel_e'(bus_addr);

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .dir_q(dir_q), .data_q(data_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(sleep), .pad_in(pad_in), .pin_q(pin_q)
  );

  gpio_port_pad #(.WIDTH(WIDTH)) u_pad (
    .dir_q(dir_q), .data_q(data_q), .pud_all(pud_all),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // Read mux: all pins answer a single access together
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_DIR:  bus_rdata = dir_q;
        SEL_DATA: bus_rdata = data_q;
        SEL_PIN:  bus_rdata = pin_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4
  no_pullup_on_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R10
  out_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R5
  pud_kills_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> pad_pu == '0);

  // R1
  reset_tristate_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam int W = 8;
  localparam int OBS_RDATA = 0, OBS_OE = 1, OBS_OUT = 2, OBS_PU = 3;

  typedef struct {
    int         obs;
    logic [W-1:0] exp;
    string      req;
  } item_t;

  logic clk = 0, rst_n = 0, pud_all = 0, sleep = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0]   bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, pad_in = 0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_pu;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .pud_all(pud_all), .sleep(sleep),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // Monitor: pops expectations one ns after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] got;
      it = sb.pop_front();
      case (it.obs)
        OBS_RDATA: got = bus_rdata;
        OBS_OE:    got = pad_oe;
        OBS_OUT:   got = pad_out;
        default:   got = pad_pu;
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s obs=%0d actual=%h expected=%h", it.req, it.obs, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_val(int obs, logic [W-1:0] exp, string req);
    item_t it;
    it.obs = obs; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd_expect(logic [1:0] a, logic [W-1:0] exp, string req);
    bus_rd = 1; bus_addr = a;
    expect_val(OBS_RDATA, exp, req);
    tick();
    bus_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    // R1: outputs in reset
    expect_val(OBS_OE, 8'h00, "R1"); expect_val(OBS_PU, 8'h00, "R1");
    tick();
    rst_n = 1;
    tick();

    // R2 / R9 direction write and readback
    wr(2'd0, 8'hF0);
    expect_val(OBS_OE, 8'hF0, "R2");
    rd_expect(2'd0, 8'hF0, "R9");

    // R3 / R4 data register drives outputs and pull-ups
    wr(2'd1, 8'hA5);
    expect_val(OBS_OUT, 8'hA0, "R3");
    expect_val(OBS_PU, 8'h05, "R4");
    expect_val(OBS_OE, 8'hF0, "R10");
    rd_expect(2'd1, 8'hA5, "R9");

    // R5 global pull-up disable
    pud_all = 1;
    expect_val(OBS_PU, 8'h00, "R5");
    tick();
    pud_all = 0;
    expect_val(OBS_PU, 8'h05, "R5");
    tick();

    // R8 writes to pin and unused addresses ignored
    wr(2'd2, 8'h3C);
    wr(2'd3, 8'hFF);
    rd_expect(2'd0, 8'hF0, "R8");
    rd_expect(2'd1, 8'hA5, "R8");
    expect_val(OBS_OE, 8'hF0, "R8");

    // R9 unused address reads zero, idle read bus zero
    rd_expect(2'd3, 8'h00, "R9");
    bus_addr = 2'd0;
    expect_val(OBS_RDATA, 8'h00, "R9");
    tick();

    // R10 flip direction: enable and level move together
    wr(2'd0, 8'h0F);
    expect_val(OBS_OE, 8'h0F, "R10");
    expect_val(OBS_OUT, 8'h05, "R10");
    expect_val(OBS_PU, 8'hA0, "R4");

    // R6 two-edge synchronizer
    pad_in = 8'h5A;
    tick();
    rd_expect(2'd2, 8'h00, "R6");
    rd_expect(2'd2, 8'h5A, "R6");
    pad_in = 8'hC3;
    tick(); tick();
    rd_expect(2'd2, 8'hC3, "R6");

    // R7 sleep freezes readback
    sleep = 1;
    pad_in = 8'h11;
    tick(); tick(); tick();
    rd_expect(2'd2, 8'hC3, "R7");
    sleep = 0;
    tick(); tick();
    rd_expect(2'd2, 8'h11, "R7");

    // R1 asynchronous reset mid-cycle, no clock edge in between
    wr(2'd0, 8'hFF);
    #0.5 rst_n = 0;
    #0.2;
    checks++;
    if (pad_oe !== 8'h00) begin
      fails++;
      $display("FAIL R1 async actual=%h expected=%h", pad_oe, 8'h00);
    end
    tick();
    expect_val(OBS_OUT, 8'h00, "R1");
    tick();
    rst_n = 1;
    tick();
    tick();
    finish_run();
  end
endmodule